// File: doc/BRIEF.md
# I2C Byte-Memory Slave Front End

This block sits between a two-wire serial bus and a 256-byte memory that is reprogrammed by a separate controller. It samples the clock and data lines through synchronizers, spots start and stop conditions, shifts bytes in and out and generates acknowledges on an open-drain data output. Three strap inputs give each device a bus identity, so up to eight devices share one bus.

A programming transaction carries a write-select word, a word address and one data byte. The stop condition that follows hands the address and data to the programming controller as a one-cycle request. A read first sets the address with a write-select word and an address byte, then sends a repeated start and a read-select word. The block then streams bytes from an auto-incrementing address counter for as long as the master acknowledges them.

While the programming controller reports busy, a read-select word is not acknowledged. This lets the master poll for the end of programming. A write-select word at that time is acknowledged and raises an abort to the controller.

Top module: `i2c_bytemem_slave`

## Requirements
- R1: A select word is acknowledged only when its bits [7:4] equal 1010 and its bits [3:1] equal `strap_sel`. Any other word gets no acknowledge, and SDA stays released until the next start.
- R2: After a matching write-select word (bit 0 = 0), the device acknowledges that word, the address byte and the data byte on each ninth clock by pulling SDA low.
- R3: A stop after a full write-select/address/data transaction raises `prog_req` for exactly one cycle, with `prog_addr` equal to the address byte and `prog_data` equal to the data byte. A stop after only a select word and an address raises no request.
- R4: A matching read-select word (bit 0 = 1) sent after a repeated start is acknowledged. The device then sends the byte stored at the current address, most significant bit first, starting right after the falling edge of that acknowledge clock.
- R5: When the master pulls SDA low on the ninth clock of a read byte, the address counter advances by one, wrapping from 255 to 0, and the next byte is sent.
- R6: When the master leaves SDA high on the ninth clock of a read byte, the device releases SDA and drives nothing until the next start.
- R7: A stop condition releases SDA (`sda_oe` = 0) within one cycle of its detection and returns the controller to idle.
- R8: While `prog_busy` is high, a read-select word is not acknowledged and starts no memory read. Once `prog_busy` is low, read-select words are acknowledged again.
- R9: A matching write-select word received while `prog_busy` is high is acknowledged and raises `prog_abort` for exactly one cycle.
- R10: Out of reset and while idle, `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_sel | input | 3 | Device identity straps |
| rd_en | output | 1 | One-cycle memory read strobe |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | 8 | Read data, valid one cycle after `rd_en` |
| prog_busy | input | 1 | Programming controller is active |
| prog_req | output | 1 | One-cycle programming request |
| prog_abort | output | 1 | One-cycle abort of active programming |
| prog_addr | output | ADDR_W | Address for the programming request |
| prog_data | output | 8 | Data for the programming request |

## Verification
Select words are tried with a wrong chip-select field and with a wrong device code, each of which must get no acknowledge, and with the matching word for each direction. This separates decoding of the strap bits from decoding of the device code. Read streams start at a mid-range address and at 255, which separates plain incrementing from wrap-around. A master acknowledge is followed by a master no-acknowledge with extra clocks afterwards, which shows both continued streaming and a silent release of SDA. Full and truncated programming transactions, with `prog_busy` high and low, separate request generation, abort generation and the ignored read-select word.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } ctl_state_e;

   typedef enum logic [1:0] {
      PH_SEL,
      PH_ADDR,
      PH_DATA,
      PH_DONE
   } byte_phase_e;

   function automatic logic sel_hit(input logic [BYTE_W-1:0] word,
                                    input logic [3:0]        code,
                                    input logic [2:0]        strap);
      return (word[7:4] == code) && (word[3:1] == strap);
   endfunction

endpackage

// File: rtl/i2c_bm_linesync.sv
module i2c_bm_linesync #(
   parameter int STAGES      = 2,
   parameter bit GLITCH_FILT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_sr;
   logic [STAGES-1:0] sda_sr;
   logic              scl_f;
   logic              sda_f;
   logic              scl_d;
   logic              sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sr <= '1;
         sda_sr <= '1;
      end else begin
         scl_sr <= {scl_sr[STAGES-2:0], scl_i};
         sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      end
   end

   generate
      if (GLITCH_FILT) begin : g_filt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_f <= 1'b1;
               sda_f <= 1'b1;
            end else begin
               if (scl_sr[STAGES-1] == scl_sr[STAGES-2]) scl_f <= scl_sr[STAGES-1];
               if (sda_sr[STAGES-1] == sda_sr[STAGES-2]) sda_f <= sda_sr[STAGES-1];
            end
         end
      end else begin : g_pass
         assign scl_f = scl_sr[STAGES-1];
         assign sda_f = sda_sr[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   assign sda_lvl   = sda_f;
   assign scl_rise  = scl_f & ~scl_d;
   assign scl_fall  = ~scl_f & scl_d;
   assign start_det = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;

endmodule

// File: rtl/i2c_bm_ctrl.sv
module i2c_bm_ctrl
   import i2c_bm_pkg::*;
#(
   parameter int         ADDR_W   = 8,
   parameter logic [3:0] DEV_CODE = 4'b1010
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_rise,
   input  logic                scl_fall,
   input  logic                start_det,
   input  logic                stop_det,
   input  logic                sda_in,
   input  logic [2:0]          strap,
   input  logic                prog_busy,
   output logic                sda_oe,
   output logic                rd_en,
   output logic [ADDR_W-1:0]   rd_addr,
   input  logic [BYTE_W-1:0]   rd_data,
   output logic                prog_req,
   output logic                prog_abort,
   output logic [ADDR_W-1:0]   prog_addr,
   output logic [BYTE_W-1:0]   prog_data
);

   ctl_state_e          state;
   byte_phase_e         phase;
   logic [2:0]          bit_cnt;
   logic [BYTE_W-1:0]   shreg;
   logic [BYTE_W-1:0]   rx_byte;
   logic [ADDR_W-1:0]   addr_q;
   logic [BYTE_W-1:0]   wdata_q;
   logic                ack_ok;
   logic                ack_on;
   logic                rd_mode;
   logic                wr_pend;
   logic                fetch_req;
   logic                fetch_cap;
   logic                m_ack;
   logic                req_q;
   logic                abort_q;

   assign rx_byte = {shreg[BYTE_W-2:0], sda_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         phase     <= PH_SEL;
         bit_cnt   <= '0;
         shreg     <= '0;
         addr_q    <= '0;
         wdata_q   <= '0;
         ack_ok    <= 1'b0;
         ack_on    <= 1'b0;
         rd_mode   <= 1'b0;
         wr_pend   <= 1'b0;
         fetch_req <= 1'b0;
         fetch_cap <= 1'b0;
         m_ack     <= 1'b0;
         req_q     <= 1'b0;
         abort_q   <= 1'b0;
      end else begin
         fetch_req <= 1'b0;
         fetch_cap <= fetch_req;
         req_q     <= 1'b0;
         abort_q   <= 1'b0;
         if (stop_det) begin
            state   <= ST_IDLE;
            ack_on  <= 1'b0;
            rd_mode <= 1'b0;
            if (wr_pend) begin
               req_q   <= 1'b1;
               wr_pend <= 1'b0;
            end
         end else if (start_det) begin
            state   <= ST_RX;
            phase   <= PH_SEL;
            bit_cnt <= '0;
            ack_on  <= 1'b0;
            rd_mode <= 1'b0;
            wr_pend <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_RX: begin
                  if (scl_rise) begin
                     if (bit_cnt == 3'd7) begin
                        state  <= ST_ACK;
                        ack_on <= 1'b0;
                        ack_ok <= 1'b0;
                        unique case (phase)
                           PH_SEL: begin
                              if (sel_hit(rx_byte, DEV_CODE, strap)) begin
                                 if (!rx_byte[0]) begin
                                    ack_ok  <= 1'b1;
                                    rd_mode <= 1'b0;
                                    phase   <= PH_ADDR;
                                    abort_q <= prog_busy;
                                 end else if (!prog_busy) begin
                                    ack_ok  <= 1'b1;
                                    rd_mode <= 1'b1;
                                    phase   <= PH_DONE;
                                 end
                              end
                           end
                           PH_ADDR: begin
                              ack_ok <= 1'b1;
                              addr_q <= rx_byte[ADDR_W-1:0];
                              phase  <= PH_DATA;
                           end
                           PH_DATA: begin
                              ack_ok  <= 1'b1;
                              wdata_q <= rx_byte;
                              wr_pend <= 1'b1;
                              phase   <= PH_DONE;
                           end
                           PH_DONE: ;
                        endcase
                     end else begin
                        shreg   <= rx_byte;
                        bit_cnt <= bit_cnt + 3'd1;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_rise && ack_on && rd_mode) fetch_req <= 1'b1;
                  if (scl_fall) begin
                     if (!ack_on) begin
                        if (ack_ok) ack_on <= 1'b1;
                        else        state  <= ST_IDLE;
                     end else begin
                        ack_on  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= rd_mode ? ST_TX : ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bit_cnt == 3'd7) begin
                        state <= ST_MACK;
                     end else begin
                        shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 3'd1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     m_ack <= ~sda_in;
                     if (!sda_in) begin
                        addr_q    <= addr_q + ADDR_W'(1);
                        fetch_req <= 1'b1;
                     end
                  end
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     state   <= m_ack ? ST_TX : ST_IDLE;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
         if (fetch_cap) shreg <= rd_data;
      end
   end

   assign sda_oe     = ((state == ST_ACK) && ack_on) ||
                       ((state == ST_TX) && !shreg[BYTE_W-1]);
   assign rd_en      = fetch_req;
   assign rd_addr    = addr_q;
   assign prog_req   = req_q;
   assign prog_abort = abort_q;
   assign prog_addr  = addr_q;
   assign prog_data  = wdata_q;

endmodule

// File: rtl/i2c_bytemem_slave.sv
module i2c_bytemem_slave
   import i2c_bm_pkg::*;
#(
   parameter int         ADDR_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter bit         GLITCH_FILT = 1'b0,
   parameter logic [3:0] DEV_CODE    = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [2:0]        strap_sel,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   input  logic              prog_busy,
   output logic              prog_req,
   output logic              prog_abort,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [7:0]        prog_data
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr
         $error("ADDR_W must lie between 1 and 8");
      end
   endgenerate

   logic sda_lvl;
   logic scl_rise;
   logic scl_fall;
   logic start_det;
   logic stop_det;

   i2c_bm_linesync #(
      .STAGES      (SYNC_STAGES),
      .GLITCH_FILT (GLITCH_FILT)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_bm_ctrl #(
      .ADDR_W   (ADDR_W),
      .DEV_CODE (DEV_CODE)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .sda_in     (sda_lvl),
      .strap      (strap_sel),
      .prog_busy  (prog_busy),
      .sda_oe     (sda_oe),
      .rd_en      (rd_en),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .prog_req   (prog_req),
      .prog_abort (prog_abort),
      .prog_addr  (prog_addr),
      .prog_data  (prog_data)
   );

endmodule

// File: rtl/i2c_bm_checker.sv
module i2c_bm_checker (
   input logic clk,
   input logic rst_n,
   input logic stop_det,
   input logic sda_oe,
   input logic prog_req,
   input logic prog_abort,
   input logic prog_busy,
   input logic rd_en
);

   a_r7_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |=> !prog_req);

   a_r3_req_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> $past(stop_det));

   a_r9_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
      prog_abort |=> !prog_abort);

   a_r9_abort_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      prog_abort |-> $past(prog_busy));

   a_r4_fetch_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);

endmodule

bind i2c_bytemem_slave i2c_bm_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stop_det   (stop_det),
   .sda_oe     (sda_oe),
   .prog_req   (prog_req),
   .prog_abort (prog_abort),
   .prog_busy  (prog_busy),
   .rd_en      (rd_en)
);

// File: tb/i2c_bytemem_slave_test.sv
`timescale 1ns/1ps
module i2c_bytemem_slave_test;

   localparam int Q = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       prog_busy = 1'b0;
   logic [2:0] strap_sel = 3'b101;
   logic       sda_oe;
   logic       sda_line;
   logic       rd_en;
   logic [7:0] rd_addr;
   logic [7:0] rd_data = 8'h00;
   logic       prog_req;
   logic       prog_abort;
   logic [7:0] prog_addr;
   logic [7:0] prog_data;

   int n_chk = 0;
   int n_fail = 0;
   int req_cnt = 0;
   int abort_cnt = 0;
   int rd_cnt = 0;
   logic [7:0] cap_addr = 8'h00;
   logic [7:0] cap_data = 8'h00;

   localparam logic [7:0] WSEL = 8'hAA;
   localparam logic [7:0] RSEL = 8'hAB;

   always #4 clk = ~clk;

   assign sda_line = m_sda & ~sda_oe;

   i2c_bytemem_slave uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (m_scl),
      .sda_i      (sda_line),
      .sda_oe     (sda_oe),
      .strap_sel  (strap_sel),
      .rd_en      (rd_en),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .prog_busy  (prog_busy),
      .prog_req   (prog_req),
      .prog_abort (prog_abort),
      .prog_addr  (prog_addr),
      .prog_data  (prog_data)
   );

   function automatic logic [7:0] memv(input logic [7:0] a);
      return a ^ 8'h5A;
   endfunction

   always @(posedge clk) begin
      if (rd_en) begin
         rd_data <= memv(rd_addr);
         rd_cnt  <= rd_cnt + 1;
      end
      if (prog_req) begin
         req_cnt  <= req_cnt + 1;
         cap_addr <= prog_addr;
         cap_data <= prog_data;
      end
      if (prog_abort) abort_cnt <= abort_cnt + 1;
   end

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start;
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b0; wq(Q/2);
   endtask

   task automatic bus_stop;
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_sda = 1'b1; wq(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wq(Q);
         m_scl = 1'b1; wq(Q);
         m_scl = 1'b0; wq(Q/2);
      end
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q/2);
      acked = (sda_line == 1'b0);
      wq(Q/2);
      m_scl = 1'b0; wq(Q/2);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      b = 8'h00;
      m_sda = 1'b1;
      for (int i = 0; i < 8; i++) begin
         wq(Q);
         m_scl = 1'b1; wq(Q/2);
         b = {b[6:0], sda_line};
         wq(Q/2);
         m_scl = 1'b0;
      end
      wq(Q/2);
      m_sda = ~give_ack; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_scl = 1'b0; wq(Q/2);
      m_sda = 1'b1;
   endtask

   task automatic t_reset;
      chk("R10 sda_oe after reset", sda_oe, 1'b0);
      chk("R3 prog_req after reset", prog_req, 1'b0);
      chk("R4 rd_en after reset", rd_en, 1'b0);
   endtask

   task automatic t_mismatch;
      logic a;
      int r0;
      r0 = req_cnt;
      bus_start;
      send_byte(8'hA4, a);
      chk("R1 wrong strap field ack", a, 1'b0);
      chk("R1 released after wrong strap", sda_oe, 1'b0);
      bus_stop;
      bus_start;
      send_byte(8'hBA, a);
      chk("R1 wrong device code ack", a, 1'b0);
      bus_stop;
      chk("R10 idle sda_oe", sda_oe, 1'b0);
      chk("R3 no request after mismatch", req_cnt, r0);
   endtask

   task automatic t_program;
      logic a;
      int r0;
      r0 = req_cnt;
      bus_start;
      send_byte(WSEL, a);
      chk("R2 write-select ack", a, 1'b1);
      send_byte(8'h3C, a);
      chk("R2 address ack", a, 1'b1);
      send_byte(8'h99, a);
      chk("R2 data ack", a, 1'b1);
      bus_stop;
      chk("R3 one request", req_cnt, r0 + 1);
      chk("R3 request address", cap_addr, 8'h3C);
      chk("R3 request data", cap_data, 8'h99);
   endtask

   task automatic t_partial;
      logic a;
      int r0;
      r0 = req_cnt;
      bus_start;
      send_byte(WSEL, a);
      send_byte(8'h21, a);
      bus_stop;
      chk("R3 no request without data", req_cnt, r0);
   endtask

   task automatic t_read;
      logic a;
      logic [7:0] d;
      int c0;
      bus_start;
      send_byte(WSEL, a);
      send_byte(8'h10, a);
      bus_start;
      send_byte(RSEL, a);
      chk("R4 read-select ack", a, 1'b1);
      recv_byte(1'b1, d);
      chk("R4 first byte", d, memv(8'h10));
      recv_byte(1'b0, d);
      chk("R5 next byte", d, memv(8'h11));
      chk("R6 released after master nack", sda_oe, 1'b0);
      c0 = rd_cnt;
      recv_byte(1'b0, d);
      chk("R6 bus silent after nack", d, 8'hFF);
      chk("R6 no fetch after nack", rd_cnt, c0);
      bus_stop;
      chk("R7 released after stop", sda_oe, 1'b0);
   endtask

   task automatic t_wrap;
      logic a;
      logic [7:0] d;
      bus_start;
      send_byte(WSEL, a);
      send_byte(8'hFF, a);
      bus_start;
      send_byte(RSEL, a);
      recv_byte(1'b1, d);
      chk("R5 byte at 255", d, memv(8'hFF));
      recv_byte(1'b0, d);
      chk("R5 wrap to 0", d, memv(8'h00));
      bus_stop;
      chk("R7 idle after read stop", sda_oe, 1'b0);
   endtask

   task automatic t_busy;
      logic a;
      logic [7:0] d;
      int c0;
      int ab0;
      prog_busy = 1'b1;
      c0 = rd_cnt;
      bus_start;
      send_byte(RSEL, a);
      chk("R8 read-select ignored while busy", a, 1'b0);
      chk("R8 no fetch while busy", rd_cnt, c0);
      bus_stop;
      ab0 = abort_cnt;
      bus_start;
      send_byte(WSEL, a);
      chk("R9 write-select ack while busy", a, 1'b1);
      chk("R9 abort raised", abort_cnt, ab0 + 1);
      bus_stop;
      prog_busy = 1'b0;
      wq(Q);
      bus_start;
      send_byte(WSEL, a);
      send_byte(8'h42, a);
      bus_start;
      send_byte(RSEL, a);
      chk("R8 read-select ack after busy", a, 1'b1);
      recv_byte(1'b0, d);
      chk("R8 read data after busy", d, memv(8'h42));
      bus_stop;
      chk("R9 no abort when idle", abort_cnt, ab0 + 1);
   endtask

   initial begin
      wq(5);
      rst_n = 1'b1;
      wq(5);
      t_reset;
      t_mismatch;
      t_program;
      t_partial;
      t_read;
      t_wrap;
      t_busy;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule